// File: doc/BRIEF.md
# Power-Gated Register Access Bridge

This block lets a host reach a register that lives inside a power-gated domain without first asking software to hold that domain awake. The host sees two 32-bit words on a simple register bus: a data word and a control word. The control word names the target domain, the direction and the target offset, and carries a start flag that clears itself.

When the host sets the start flag, the bridge raises a wake request to the chosen domain and waits for its acknowledge. It then performs one 32-bit transfer on a downstream register bus. After the transfer it drops the wake request and waits for the acknowledge to fall. Only then does it clear the start flag. A read leaves the fetched word in the data word.

The host polls the control word until the start flag reads zero. A wake acknowledge that never arrives, and a domain code that names no domain, both end the access with a sticky error flag set. A 64-bit value takes two accesses, one at the offset and one at the offset plus 4.

Top module: `gated_reg_bridge`

## Requirements
- R1: After reset, both host words read as zero and no wake request and no downstream request are active.
- R2: The data word is at host address 0xF00 and the control word at 0xF04. The control word fields are: bit 31 start flag, bit 30 error flag, bits 29:28 domain, bit 24 direction, bits 23:0 target offset. All other control bits read 0, and every other host address reads 0. Host read data appears on the cycle after the read strobe.
- R3: Setting the start flag with direction 0 (write) raises wake request bit d on the next cycle, where domain 0 drives bit 0, domain 1 drives bit 1 and domain 2 drives bit 2. Once the selected acknowledge is seen, the bridge holds a downstream write of the data word to the target offset until the transfer completes.
- R4: With direction 1 (read), the downstream word returned at completion is stored in the data word. A 64-bit value is read with two accesses, at the offset and at the offset plus 4.
- R5: The wake request stays high from launch until the downstream transfer completes and is high whenever a downstream request is active. The start flag clears only after the wake request is low and the selected acknowledge has fallen.
- R6: A control write with the start flag clear only loads the fields and starts no access. After completion the start flag reads 0.
- R7: While the start flag is set, host writes to both the data word and the control word are ignored, including a write of 1 to the error flag.
- R8: If the selected acknowledge does not arrive within the wake limit (the wake_limit input, in cycles), the bridge drops the wake request, clears the start flag and sets the error flag. It makes no downstream access.
- R9: The error flag is sticky. An idle control write with bit 30 set clears it; an idle control write with bit 30 clear leaves it set.
- R10: A control write with the start flag set and domain code 3 leaves the start flag at 0 and sets the error flag on the next cycle. It raises no wake request and makes no downstream access.
- R11: At most one wake request bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| wake_limit | input | TMO_W | Cycles to wait for a wake acknowledge (nonzero) |
| wake_req | output | 3 | Per-domain wake request |
| wake_ack | input | 3 | Per-domain wake acknowledge |
| dn_req | output | 1 | Downstream transfer request, held until done |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | OFS_W | Downstream register offset |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid with dn_done |
| dn_done | input | 1 | Downstream transfer completion pulse |

## Verification
The bench builds the bridge with a 12-bit host address, a 24-bit offset and an 8-bit timeout counter. It drives wake_limit at run time: a limit of 8 makes the acknowledge timeout happen within a few polls. A limit of 200 holds an access in its wake phase long enough to write into both host words while the start flag is set. Per-domain acknowledge enables in the domain model let each domain be kept asleep on its own, which makes the abort path and the busy window reachable. Offsets near the top of the 24-bit field are used to check the field position.

// File: rtl/grb_pkg.sv
package grb_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned DOM_CNT = 3;
  localparam int unsigned GO_BIT  = 31;
  localparam int unsigned ERR_BIT = 30;
  localparam int unsigned DOM_LSB = 28;
  localparam int unsigned OP_BIT  = 24;

  typedef enum logic [1:0] {
    DOM_BLT = 2'd0,
    DOM_RND = 2'd1,
    DOM_MED = 2'd2,
    DOM_BAD = 2'd3
  } dom_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_XFER,
    ST_DRAIN
  } seq_st_e;
endpackage

// File: rtl/grb_host_regs.sv
module grb_host_regs
  import grb_pkg::*;
#(
  parameter int unsigned HOST_AW  = 12,
  parameter int unsigned OFS_W    = 24,
  parameter int unsigned DATA_OFS = 32'hF00,
  parameter int unsigned CTRL_OFS = 32'hF04
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [HOST_AW-1:0] addr,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata,
  input  logic               fin,
  input  logic               fin_err,
  input  logic               ld_en,
  input  logic [WORD_W-1:0]  ld_data,
  output logic               launch,
  output logic               go,
  output logic               err,
  output logic [1:0]         dom,
  output logic               op,
  output logic [OFS_W-1:0]   ofs,
  output logic [WORD_W-1:0]  data
);
  logic               sel_data, sel_ctrl, wr_ok, ctrl_wr, bad_go;
  logic [1:0]         new_dom;
  logic [WORD_W-1:0]  ctrl_word, rd_mux, rdata_q, data_q;
  logic               go_q, err_q, op_q;
  logic [1:0]         dom_q;
  logic [OFS_W-1:0]   ofs_q;
  logic [3:0]         unused_ctrl_bits;

  assign sel_data = (addr == HOST_AW'(DATA_OFS));
  assign sel_ctrl = (addr == HOST_AW'(CTRL_OFS));
  assign wr_ok    = wr_en && !go_q;
  assign ctrl_wr  = wr_ok && sel_ctrl;
  assign new_dom  = wdata[DOM_LSB +: 2];
  assign launch   = ctrl_wr && wdata[GO_BIT] && (new_dom != DOM_BAD);
  assign bad_go   = ctrl_wr && wdata[GO_BIT] && (new_dom == DOM_BAD);
  assign unused_ctrl_bits = {wdata[27:25], ^wdata[23:OFS_W-1]};

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[GO_BIT]           = go_q;
    ctrl_word[ERR_BIT]          = err_q;
    ctrl_word[DOM_LSB +: 2]     = dom_q;
    ctrl_word[OP_BIT]           = op_q;
    ctrl_word[OFS_W-1:0]        = ofs_q;
  end

  always_comb begin
    if (sel_data)      rd_mux = data_q;
    else if (sel_ctrl) rd_mux = ctrl_word;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      go_q    <= 1'b0;
      err_q   <= 1'b0;
      op_q    <= 1'b0;
      dom_q   <= '0;
      ofs_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ok && sel_data) data_q <= wdata;
      else if (ld_en)        data_q <= ld_data;
      if (ctrl_wr) begin
        dom_q <= new_dom;
        op_q  <= wdata[OP_BIT];
        ofs_q <= wdata[OFS_W-1:0];
      end
      if (launch)   go_q <= 1'b1;
      else if (fin) go_q <= 1'b0;
      if (bad_go || (fin && fin_err))    err_q <= 1'b1;
      else if (ctrl_wr && wdata[ERR_BIT]) err_q <= 1'b0;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;
  assign go    = go_q;
  assign err   = err_q;
  assign dom   = dom_q;
  assign op    = op_q;
  assign ofs   = ofs_q;
  assign data  = data_q;
endmodule

// File: rtl/grb_seq.sv
module grb_seq
  import grb_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              op,
  input  logic              ack,
  input  logic [TMO_W-1:0]  wake_limit,
  input  logic              dn_done,
  input  logic [WORD_W-1:0] dn_rdata,
  output logic              wake_on,
  output logic              dn_req,
  output logic              fin,
  output logic              fin_err,
  output logic              ld_en,
  output logic [WORD_W-1:0] ld_data
);
  seq_st_e          st_q;
  logic [TMO_W-1:0] cnt_q;
  logic             wake_q, req_q, expire;

  assign expire = (st_q == ST_WAKE) && !ack && (cnt_q == wake_limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      wake_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q   <= ST_WAKE;
          cnt_q  <= '0;
          wake_q <= 1'b1;
        end
        ST_WAKE: begin
          if (ack) begin
            st_q  <= ST_XFER;
            req_q <= 1'b1;
          end else if (expire) begin
            st_q   <= ST_IDLE;
            wake_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_XFER: if (dn_done) begin
          st_q   <= ST_DRAIN;
          req_q  <= 1'b0;
          wake_q <= 1'b0;
        end
        ST_DRAIN: if (!ack) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wake_on = wake_q;
  assign dn_req  = req_q;
  assign fin     = expire || ((st_q == ST_DRAIN) && !ack);
  assign fin_err = expire;
  assign ld_en   = (st_q == ST_XFER) && dn_done && op;
  assign ld_data = dn_rdata;
endmodule

// File: rtl/grb_wake_sel.sv
module grb_wake_sel #(
  parameter int unsigned N_DOM = 3
) (
  input  logic             on,
  input  logic [1:0]       dom,
  input  logic [N_DOM-1:0] ack_in,
  output logic [N_DOM-1:0] req_out,
  output logic             ack_sel
);
  logic [N_DOM-1:0] hit;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign hit[d]     = (dom == 2'(d));
    assign req_out[d] = on && hit[d];
  end

  assign ack_sel = |(ack_in & hit);
endmodule

// File: rtl/gated_reg_bridge.sv
module gated_reg_bridge
  import grb_pkg::*;
#(
  parameter int unsigned HOST_AW  = 12,
  parameter int unsigned OFS_W    = 24,
  parameter int unsigned TMO_W    = 16,
  parameter int unsigned DATA_OFS = 32'hF00,
  parameter int unsigned CTRL_OFS = 32'hF04
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic [TMO_W-1:0]   wake_limit,
  output logic [2:0]         wake_req,
  input  logic [2:0]         wake_ack,
  output logic               dn_req,
  output logic               dn_we,
  output logic [OFS_W-1:0]   dn_addr,
  output logic [31:0]        dn_wdata,
  input  logic [31:0]        dn_rdata,
  input  logic               dn_done
);
  logic              launch, go, err, op, fin, fin_err, ld_en, wake_on, ack_sel;
  logic [1:0]        dom;
  logic [OFS_W-1:0]  ofs;
  logic [WORD_W-1:0] data, ld_data;

  grb_host_regs #(
    .HOST_AW(HOST_AW), .OFS_W(OFS_W), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(host_wr_en), .rd_en(host_rd_en),
    .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
    .fin(fin), .fin_err(fin_err), .ld_en(ld_en), .ld_data(ld_data),
    .launch(launch), .go(go), .err(err), .dom(dom), .op(op), .ofs(ofs),
    .data(data)
  );

  grb_seq #(.TMO_W(TMO_W)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .op(op), .ack(ack_sel),
    .wake_limit(wake_limit), .dn_done(dn_done), .dn_rdata(dn_rdata),
    .wake_on(wake_on), .dn_req(dn_req), .fin(fin), .fin_err(fin_err),
    .ld_en(ld_en), .ld_data(ld_data)
  );

  grb_wake_sel #(.N_DOM(DOM_CNT)) u_wsel (
    .on(wake_on), .dom(dom), .ack_in(wake_ack), .req_out(wake_req),
    .ack_sel(ack_sel)
  );

  assign dn_we    = !op;
  assign dn_addr  = ofs;
  assign dn_wdata = data;
endmodule

// File: rtl/grb_checker.sv
module grb_checker #(
  parameter int unsigned HOST_AW  = 12,
  parameter int unsigned OFS_W    = 24,
  parameter int unsigned CTRL_OFS = 32'hF04
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr_en,
  input logic [HOST_AW-1:0] host_addr,
  input logic [31:0]        host_wdata,
  input logic [2:0]         wake_req,
  input logic               dn_req,
  input logic               dn_done,
  input logic               dn_we,
  input logic [OFS_W-1:0]   dn_addr,
  input logic [31:0]        dn_wdata,
  input logic               go,
  input logic               err
);
  AST_WAKE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wake_req)); // R11

  AST_XFER_AWAKE: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> (wake_req != 3'b000)); // R5

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_done) |=> dn_req); // R3

  AST_BUSY_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    go |=> ($stable(dn_addr) && $stable(dn_we))); // R7

  AST_BUSY_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (go && !dn_req) |=> $stable(dn_wdata)); // R7

  AST_GO_FALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(go) |-> (wake_req == 3'b000 && !dn_req)); // R5

  AST_IDLE_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    !go |-> (wake_req == 3'b000 && !dn_req)); // R6

  AST_BAD_DOM_REJECT: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && !go && host_addr == HOST_AW'(CTRL_OFS) && host_wdata[31]
     && host_wdata[29:28] == 2'b11) |=> (!go && err && wake_req == 3'b000)); // R10
endmodule

bind gated_reg_bridge grb_checker #(
  .HOST_AW(HOST_AW), .OFS_W(OFS_W), .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_addr(host_addr),
  .host_wdata(host_wdata), .wake_req(wake_req), .dn_req(dn_req),
  .dn_done(dn_done), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
  .go(go), .err(err)
);

// File: tb/tb_gated_reg_bridge.sv
module tb_gated_reg_bridge;
  localparam int unsigned HOST_AW = 12;
  localparam int unsigned OFS_W   = 24;
  localparam int unsigned TMO_W   = 8;
  localparam logic [11:0] A_DATA  = 12'hF00;
  localparam logic [11:0] A_CTRL  = 12'hF04;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [HOST_AW-1:0] host_addr = '0;
  logic [31:0]        host_wdata = '0, host_rdata;
  logic [TMO_W-1:0]   wake_limit = 8'd50;
  logic [2:0]         wake_req, wake_ack = 3'b000, ack_en = 3'b111;
  logic               dn_req, dn_we, dn_done = 1'b0;
  logic [OFS_W-1:0]   dn_addr;
  logic [31:0]        dn_wdata, dn_rdata = '0;

  int checks = 0, fails = 0, cycles = 0, dn_count = 0, viol = 0, dly = 0;
  logic [OFS_W-1:0] log_addr;
  logic [31:0]      log_data;
  logic             log_we;
  logic [2:0]       wake_seen = 3'b000;

  gated_reg_bridge #(.HOST_AW(HOST_AW), .OFS_W(OFS_W), .TMO_W(TMO_W)) dut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .wake_limit(wake_limit), .wake_req(wake_req), .wake_ack(wake_ack),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata), .dn_done(dn_done)
  );

  always #5 clk = ~clk;

  // Domain and downstream models
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      wake_ack <= 3'b000;
      dn_done  <= 1'b0;
      dly      <= 0;
    end else begin
      wake_ack  <= wake_req & ack_en;
      wake_seen <= wake_seen | wake_req;
      if (dn_req && wake_req == 3'b000) viol <= viol + 1;
      if ($countones(wake_req) > 1)     viol <= viol + 1;
      if (dn_req && !dn_done) begin
        if (dly == 1) begin
          dn_done  <= 1'b1;
          dn_rdata <= {8'h00, dn_addr} ^ 32'h5A5A_0000;
        end
        dly <= dly + 1;
      end else begin
        dn_done <= 1'b0;
        dly     <= 0;
      end
      if (dn_req && dn_done) begin
        dn_count <= dn_count + 1;
        log_addr <= dn_addr;
        log_data <= dn_wdata;
        log_we   <= dn_we;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] c);
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 100; i++) begin
      host_read(A_CTRL, c);
      if (!c[31]) break;
    end
  endtask

  function automatic logic [31:0] ctl(input bit go, input bit er, input logic [1:0] d,
                                      input bit op, input logic [23:0] o);
    return {go, er, d, 3'b000, op, o};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    check(wake_req == 3'b000 && !dn_req, "R1 outputs idle", {29'b0, wake_req}, 0);
    host_read(A_DATA, v); check(v == 0, "R1 data word", v, 0);
    host_read(A_CTRL, v); check(v == 0, "R1 control word", v, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    int n0 = dn_count;
    host_write(A_DATA, 32'h1234_5678);
    host_read(A_DATA, v); check(v == 32'h1234_5678, "R2 data readback", v, 32'h1234_5678);
    host_write(A_CTRL, ctl(0, 0, 2, 1, 24'hABCDEF));
    host_read(A_CTRL, v); check(v == 32'h21AB_CDEF, "R2 control fields", v, 32'h21AB_CDEF);
    host_write(A_CTRL, 32'h0E00_0000);
    host_read(A_CTRL, v); check(v == 0, "R2 reserved bits read 0", v, 0);
    host_read(12'h100, v); check(v == 0, "R2 unmapped address", v, 0);
    repeat (4) @(negedge clk);
    check(dn_count == n0 && wake_req == 0, "R6 no launch without go", dn_count, n0);
  endtask

  task automatic t_write();
    logic [31:0] c;
    int n0 = dn_count;
    host_write(A_DATA, 32'hCAFE_0001);
    host_write(A_CTRL, ctl(0, 0, 0, 0, 24'h000040));
    host_write(A_CTRL, ctl(1, 0, 0, 0, 24'h000040));
    check(wake_req == 3'b001, "R3 blitter wake next cycle", {29'b0, wake_req}, 1);
    wait_idle(c);
    check(c == ctl(0, 0, 0, 0, 24'h40), "R6 go clears after write", c, ctl(0, 0, 0, 0, 24'h40));
    check(dn_count == n0 + 1 && log_we && log_addr == 24'h40, "R3 downstream write target",
          {8'h0, log_addr}, 32'h40);
    check(log_data == 32'hCAFE_0001, "R3 downstream write data", log_data, 32'hCAFE_0001);
    check(wake_req == 0 && wake_ack == 0, "R5 wake released at completion", {29'b0, wake_ack}, 0);
  endtask

  task automatic t_read();
    logic [31:0] c, v;
    host_write(A_CTRL, ctl(1, 0, 1, 1, 24'h000100));
    check(wake_req == 3'b010, "R3 render wake bit", {29'b0, wake_req}, 2);
    wait_idle(c);
    host_read(A_DATA, v);
    check(v == 32'h5A5A_0100, "R4 read data stored", v, 32'h5A5A_0100);
    check(!log_we, "R4 downstream direction read", {31'b0, log_we}, 0);
    for (int k = 0; k < 2; k++) begin
      logic [23:0] o = 24'hFFFFF8 + 24'(4 * k);
      host_write(A_CTRL, ctl(1, 0, 2, 1, o));
      wait_idle(c);
      host_read(A_DATA, v);
      check(v == ({8'h0, o} ^ 32'h5A5A_0000), "R4 64-bit half read", v, {8'h0, o} ^ 32'h5A5A_0000);
    end
    check(wake_seen[2], "R3 media wake bit", {29'b0, wake_seen}, 3'b100);
  endtask

  task automatic t_busy();
    logic [31:0] c, v;
    wake_limit = 8'd200;
    ack_en = 3'b101;
    host_write(A_DATA, 32'h1111_0000);
    host_write(A_CTRL, ctl(1, 0, 1, 0, 24'h000080));
    host_write(A_DATA, 32'h2222_0000);
    host_write(A_CTRL, ctl(1, 0, 2, 1, 24'h000099));
    host_write(A_CTRL, 32'h4000_0000);
    host_read(A_CTRL, c);
    check(c == ctl(1, 0, 1, 0, 24'h80), "R7 control ignored while busy", c, ctl(1, 0, 1, 0, 24'h80));
    host_read(A_DATA, v);
    check(v == 32'h1111_0000, "R7 data ignored while busy", v, 32'h1111_0000);
    ack_en = 3'b111;
    wait_idle(c);
    check(log_data == 32'h1111_0000 && log_addr == 24'h80, "R7 original access done", log_data, 32'h1111_0000);
  endtask

  task automatic t_timeout();
    logic [31:0] c;
    int n0 = dn_count;
    wake_limit = 8'd8;
    ack_en = 3'b011;
    host_write(A_CTRL, ctl(1, 0, 2, 0, 24'h000010));
    wait_idle(c);
    check(c == ctl(0, 1, 2, 0, 24'h10), "R8 abort sets error, clears go", c, ctl(0, 1, 2, 0, 24'h10));
    check(dn_count == n0 && wake_req == 0, "R8 no downstream access", dn_count, n0);
    ack_en = 3'b111;
    wake_limit = 8'd50;
  endtask

  task automatic t_sticky();
    logic [31:0] c;
    host_write(A_CTRL, 32'h0000_0000);
    host_read(A_CTRL, c); check(c == 32'h4000_0000, "R9 error stays set", c, 32'h4000_0000);
    host_write(A_CTRL, 32'h4000_0000);
    host_read(A_CTRL, c); check(c == 0, "R9 write 1 clears error", c, 0);
  endtask

  task automatic t_bad_dom();
    logic [31:0] c;
    int n0 = dn_count;
    logic [2:0] s0;
    wake_seen = 3'b000;
    host_write(A_CTRL, ctl(1, 0, 3, 0, 24'h000005));
    host_read(A_CTRL, c);
    check(c == 32'h7000_0005, "R10 invalid domain rejected", c, 32'h7000_0005);
    repeat (4) @(negedge clk);
    s0 = wake_seen;
    check(dn_count == n0 && s0 == 0, "R10 no wake or access", {29'b0, s0}, 0);
    host_write(A_CTRL, 32'h4000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_write();
    t_read();
    t_busy();
    t_timeout();
    t_sticky();
    t_bad_dom();
    check(viol == 0, "R11 single wake and R5 wake during transfer", viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected done", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule